// File: doc/BRIEF.md
# Receive FIFO Flow-Control Line Driver with Hysteresis

This block decides when a serial receiver asks its far-end partner to pause. Each clock it looks at the current fill count of the receive FIFO, from 0 to 64 entries, and drives an active-low request-to-send line. The line goes high to ask the sender to stop once the FIFO is full enough. It goes low again only after the FIFO has drained well below that point. Because the stop point and the resume point differ, the line does not chatter while the count hovers near one threshold.

Software chooses the thresholds through four fields. A 2-bit table select picks one of four trigger-level lists. A 2-bit trigger select picks one entry of that list. A 4-bit hysteresis code matters only with the fourth list. A flow-control enable completes the set.

In the first three lists, the stop point is the list entry one step above the chosen trigger, and the resume point is the entry one step below. In the fourth list, a non-zero hysteresis code instead places the two points a fixed distance either side of the chosen trigger. A zero code falls back to the neighbour rule.

The decision lives in a three-state machine:
- **ST_OFF**: flow control disabled, line low.
- **ST_OPEN**: sender allowed, line low.
- **ST_HELD**: sender paused, line high.

Transitions:
- **Any state to ST_OFF** when the enable is low.
- **ST_OFF to ST_HELD** when the count is at or above the stop point.
- **ST_OFF to ST_OPEN** in every other enabled case.
- **ST_OPEN to ST_HELD** on reaching the stop point.
- **ST_HELD to ST_OPEN** on falling to the resume point.

Top module: `rts_flow_ctrl`

## Requirements
- R1: While reset is active and right after it, the state is ST_OFF and `rts_n` is 0.
- R2: With `fc_en` low, `rts_n` is 0 whatever the count and the other fields.
- R3: The trigger lists, indexed by `trig_sel` 0..3 in ascending order, are:
  - `tbl_sel`=0: 1, 4, 8, 14
  - `tbl_sel`=1: 8, 16, 24, 28
  - `tbl_sel`=2: 8, 16, 56, 60
  - `tbl_sel`=3: 4, 16, 32, 48

  For `tbl_sel` 0..2, `rts_n` goes to 1 when the count is at least the entry at index `trig_sel`+1. For example, table 2 with trigger 56 stops at 60.
- R4: For `tbl_sel` 0..2, `rts_n` returns to 0 when the count is at most the entry at index `trig_sel`−1. For example, table 2 with trigger 56 resumes at 16.
- R5: While the count lies strictly between the resume point and the stop point, `rts_n` keeps its previous value.
- R6: The neighbour index saturates at the list ends. Index 3 uses entry 3 as its stop point, and index 0 uses entry 0 as its resume point. For example, table 2 with trigger 60 stops at 60 and resumes at 56.
- R7: With `tbl_sel`=3 and `hyst_sel`=0, the neighbour rule of R3, R4 and R6 applies to the fourth list.
- R8: With `tbl_sel`=3 and `hyst_sel`=n, where n is 1..15, the stop point is trigger+4n clamped to 64, and the resume point is trigger−4n clamped to 0.
- R9: With `tbl_sel` 0..2, `hyst_sel` has no effect on `rts_n`.
- R10: `rts_n` follows its inputs with one cycle of latency. A count presented before a rising edge shows its effect just after that edge, not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fc_en | input | 1 | Enable for automatic flow control |
| tbl_sel | input | 2 | Trigger list select, 0..3 |
| trig_sel | input | 2 | Index of the trigger within the list |
| hyst_sel | input | 4 | Hysteresis code, used with list 3 only |
| rx_count | input | 7 | Current receive FIFO fill count, 0..64 |
| rts_n | output | 1 | Active-low request-to-send; 1 asks the sender to pause |

## Verification
A state register stuck in ST_OPEN or ST_HELD shows up as a wrong `rts_n` on the first edge after the count crosses a threshold. A wrong threshold shows up as a pause or resume one count early or late. Either fault is visible one cycle after the stimulus.

The subtle failure is a lost hold: the line releases too early inside the hysteresis band. It appears only when the count rises and then falls back between the two points. For that reason the random count walk crosses both points repeatedly under every table and code.

// File: rtl/rts_pkg.sv
package rts_pkg;
    localparam int FIFO_DEPTH = 64;
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);
    localparam int NUM_TBL    = 4;
    localparam int NUM_LVL    = 4;
    localparam int HYST_W     = 4;
    localparam int HYST_STEP  = 4;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_OPEN = 2'd1,
        ST_HELD = 2'd2
    } rts_state_e;

    // Trigger level for table t, index i (ascending within each table).
    function automatic logic [CNT_W-1:0] trig_level(input logic [1:0] t, input logic [1:0] i);
        logic [CNT_W-1:0] v;
        unique case ({t, i})
            4'b00_00: v = 7'd1;
            4'b00_01: v = 7'd4;
            4'b00_10: v = 7'd8;
            4'b00_11: v = 7'd14;
            4'b01_00: v = 7'd8;
            4'b01_01: v = 7'd16;
            4'b01_10: v = 7'd24;
            4'b01_11: v = 7'd28;
            4'b10_00: v = 7'd8;
            4'b10_01: v = 7'd16;
            4'b10_10: v = 7'd56;
            4'b10_11: v = 7'd60;
            4'b11_00: v = 7'd4;
            4'b11_01: v = 7'd16;
            4'b11_10: v = 7'd32;
            default:  v = 7'd48;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/rts_trig_lut.sv
module rts_trig_lut
    import rts_pkg::*;
#(
    parameter int LVL_W = CNT_W
) (
    input  logic [1:0]       tbl_sel,
    input  logic [1:0]       trig_sel,
    output logic [LVL_W-1:0] lvl_sel,
    output logic [LVL_W-1:0] lvl_above,
    output logic [LVL_W-1:0] lvl_below
);
    localparam int TOP_IDX = NUM_LVL - 1;

    logic [LVL_W-1:0] lvls [NUM_LVL];

    // Build the selected table as a small vector of levels.
    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        assign lvls[g] = trig_level(tbl_sel, 2'(g));
    end

    logic [1:0] idx_up;
    logic [1:0] idx_dn;

    always_comb begin
        idx_up = (int'(trig_sel) == TOP_IDX) ? trig_sel : trig_sel + 2'd1;
        idx_dn = (trig_sel == 2'd0) ? trig_sel : trig_sel - 2'd1;
    end

    assign lvl_sel   = lvls[trig_sel];
    assign lvl_above = lvls[idx_up];
    assign lvl_below = lvls[idx_dn];
endmodule

// File: rtl/rts_thresh.sv
module rts_thresh
    import rts_pkg::*;
#(
    parameter int LVL_W  = CNT_W,
    parameter int H_W    = HYST_W,
    parameter int H_STEP = HYST_STEP,
    parameter int DEPTH  = FIFO_DEPTH
) (
    input  logic [1:0]       tbl_sel,
    input  logic [H_W-1:0]   hyst_sel,
    input  logic [LVL_W-1:0] lvl_sel,
    input  logic [LVL_W-1:0] lvl_above,
    input  logic [LVL_W-1:0] lvl_below,
    output logic [LVL_W-1:0] up_th,
    output logic [LVL_W-1:0] dn_th
);
    localparam int SUM_W = LVL_W + H_W + 4;

    logic [SUM_W-1:0] offs;
    logic [SUM_W-1:0] hi_sum;
    logic             use_hyst;

    always_comb begin
        use_hyst = (tbl_sel == 2'd3) && (hyst_sel != '0);
        offs     = SUM_W'(hyst_sel) * SUM_W'(H_STEP);
        hi_sum   = SUM_W'(lvl_sel) + offs;

        if (use_hyst) begin
            up_th = (hi_sum > SUM_W'(DEPTH)) ? LVL_W'(DEPTH) : LVL_W'(hi_sum);
            dn_th = (SUM_W'(lvl_sel) > offs) ? LVL_W'(SUM_W'(lvl_sel) - offs) : '0;
        end else begin
            up_th = lvl_above;
            dn_th = lvl_below;
        end
    end
endmodule

// File: rtl/rts_fsm.sv
module rts_fsm
    import rts_pkg::*;
#(
    parameter int LVL_W = CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fc_en,
    input  logic [LVL_W-1:0] rx_count,
    input  logic [LVL_W-1:0] up_th,
    input  logic [LVL_W-1:0] dn_th,
    output logic             rts_n
);
    rts_state_e state_q;
    rts_state_e state_d;
    logic       hit_up;
    logic       hit_dn;

    assign hit_up = rx_count >= up_th;
    assign hit_dn = (rx_count <= dn_th) && !hit_up;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  state_d = !fc_en ? ST_OFF : (hit_up ? ST_HELD : ST_OPEN);
            ST_OPEN: state_d = !fc_en ? ST_OFF : (hit_up ? ST_HELD : ST_OPEN);
            ST_HELD: state_d = !fc_en ? ST_OFF : (hit_dn ? ST_OPEN : ST_HELD);
            default: state_d = ST_OFF;
        endcase
    end

    always_comb begin
        rts_n = (state_q == ST_HELD);
    end
endmodule

// File: rtl/rts_flow_ctrl.sv
module rts_flow_ctrl
    import rts_pkg::*;
#(
    parameter int CNT_W_P = CNT_W,
    parameter int HYST_WP = HYST_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fc_en,
    input  logic [1:0]         tbl_sel,
    input  logic [1:0]         trig_sel,
    input  logic [HYST_WP-1:0] hyst_sel,
    input  logic [CNT_W_P-1:0] rx_count,
    output logic               rts_n
);
    logic [CNT_W_P-1:0] lvl_sel;
    logic [CNT_W_P-1:0] lvl_above;
    logic [CNT_W_P-1:0] lvl_below;
    logic [CNT_W_P-1:0] up_th;
    logic [CNT_W_P-1:0] dn_th;

    rts_trig_lut #(.LVL_W(CNT_W_P)) lut_i (
        .tbl_sel   (tbl_sel),
        .trig_sel  (trig_sel),
        .lvl_sel   (lvl_sel),
        .lvl_above (lvl_above),
        .lvl_below (lvl_below)
    );

    rts_thresh #(.LVL_W(CNT_W_P), .H_W(HYST_WP)) thr_i (
        .tbl_sel   (tbl_sel),
        .hyst_sel  (hyst_sel),
        .lvl_sel   (lvl_sel),
        .lvl_above (lvl_above),
        .lvl_below (lvl_below),
        .up_th     (up_th),
        .dn_th     (dn_th)
    );

    rts_fsm #(.LVL_W(CNT_W_P)) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .fc_en    (fc_en),
        .rx_count (rx_count),
        .up_th    (up_th),
        .dn_th    (dn_th),
        .rts_n    (rts_n)
    );
endmodule

// File: rtl/rts_flow_chk.sv
module rts_flow_chk #(
    parameter int CNT_W_P = 7,
    parameter int DEPTH   = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               fc_en,
    input logic [CNT_W_P-1:0] rx_count,
    input logic [CNT_W_P-1:0] up_th,
    input logic [CNT_W_P-1:0] dn_th,
    input logic               rts_n
);
    AST_RESET_LOW: assert property (@(posedge clk) !rst_n |-> !rts_n); // R1
    AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !fc_en |=> !rts_n); // R2
    AST_STOP_AT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_en && rx_count >= up_th) |=> rts_n); // R3
    AST_RESUME_AT_DN: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_en && rx_count <= dn_th && rx_count < up_th) |=> !rts_n); // R4
    AST_HOLD_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_en && rx_count > dn_th && rx_count < up_th) |=> $stable(rts_n)); // R5
    AST_TH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        up_th > dn_th); // R6
    AST_TH_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        int'(up_th) <= DEPTH); // R8
endmodule

bind rts_flow_ctrl rts_flow_chk #(.CNT_W_P(CNT_W_P)) chk_i (.*);

// File: tb/rts_flow_ctrl_tb.sv
module rts_flow_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fc_en = 1'b0;
    logic [1:0] tbl_sel = 2'd0;
    logic [1:0] trig_sel = 2'd0;
    logic [3:0] hyst_sel = 4'd0;
    logic [6:0] rx_count = 7'd0;
    logic       rts_n;

    int n_run  = 0;
    int n_fail = 0;
    logic exp_rts = 1'b0;
    bit   done = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    rts_flow_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .fc_en(fc_en), .tbl_sel(tbl_sel),
        .trig_sel(trig_sel), .hyst_sel(hyst_sel), .rx_count(rx_count), .rts_n(rts_n)
    );

    function automatic int lvl(input int t, input int i);
        int a [4][4] = '{'{1,4,8,14}, '{8,16,24,28}, '{8,16,56,60}, '{4,16,32,48}};
        return a[t][i];
    endfunction

    function automatic int up_pt(input int t, input int i, input int h);
        if (t == 3 && h != 0) return (lvl(t,i) + 4*h > 64) ? 64 : lvl(t,i) + 4*h;
        return lvl(t, (i == 3) ? 3 : i + 1);
    endfunction

    function automatic int dn_pt(input int t, input int i, input int h);
        if (t == 3 && h != 0) return (lvl(t,i) - 4*h < 0) ? 0 : lvl(t,i) - 4*h;
        return lvl(t, (i == 0) ? 0 : i - 1);
    endfunction

    function automatic logic model(input logic prev, input logic en, input int t,
                                   input int i, input int h, input int c);
        if (!en) return 1'b0;
        if (c >= up_pt(t,i,h)) return 1'b1;
        if (c <= dn_pt(t,i,h)) return 1'b0;
        return prev;
    endfunction

    task automatic check(input string req, input logic exp);
        n_run++;
        if (rts_n !== exp) begin
            n_fail++;
            $display("FAIL %s: rts_n=%b expected %b (tbl=%0d trig=%0d hyst=%0d cnt=%0d en=%b)",
                     req, rts_n, exp, tbl_sel, trig_sel, hyst_sel, rx_count, fc_en);
        end
    endtask

    task automatic apply(input logic en, input int t, input int i, input int h,
                         input int c, input string req);
        @(negedge clk);
        fc_en = en;
        tbl_sel = 2'(t);
        trig_sel = 2'(i);
        hyst_sel = 4'(h);
        rx_count = 7'(c);
        exp_rts = model(exp_rts, en, t, i, h, c);
        @(posedge clk);
        #1;
        check(req, exp_rts);
    endtask

    initial begin
        #40000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        check("R1", 1'b0);                     // R1 during reset
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1", 1'b0);                     // R1 right after reset

        // R2: disabled, full FIFO
        apply(1'b0, 2, 2, 0, 64, "R2");
        apply(1'b0, 0, 0, 0, 64, "R2");

        // R3 / R4 / R5: table 2, trigger 56 -> stop 60, resume 16
        apply(1'b1, 2, 2, 0, 59, "R3");
        apply(1'b1, 2, 2, 0, 60, "R3");
        apply(1'b1, 2, 2, 0, 58, "R5");
        apply(1'b1, 2, 2, 0, 17, "R5");
        apply(1'b1, 2, 2, 0, 16, "R4");
        apply(1'b1, 2, 2, 0, 40, "R5");

        // R6: saturation at both list ends
        apply(1'b1, 2, 3, 0, 60, "R6");
        apply(1'b1, 2, 3, 0, 57, "R6");
        apply(1'b1, 2, 3, 0, 56, "R6");
        apply(1'b1, 0, 0, 0, 3, "R6");
        apply(1'b1, 0, 0, 0, 4, "R6");
        apply(1'b1, 0, 0, 0, 2, "R6");
        apply(1'b1, 0, 0, 0, 1, "R6");

        // R7: list 3, code 0, trigger 32 -> stop 48, resume 16
        apply(1'b1, 3, 2, 0, 47, "R7");
        apply(1'b1, 3, 2, 0, 48, "R7");
        apply(1'b1, 3, 2, 0, 17, "R7");
        apply(1'b1, 3, 2, 0, 16, "R7");

        // R8: trigger 16, code 3 -> 28 / 4; trigger 48, code 15 -> clamp 64 / 0
        apply(1'b1, 3, 1, 3, 27, "R8");
        apply(1'b1, 3, 1, 3, 28, "R8");
        apply(1'b1, 3, 1, 3, 5, "R8");
        apply(1'b1, 3, 1, 3, 4, "R8");
        apply(1'b1, 3, 3, 15, 63, "R8");
        apply(1'b1, 3, 3, 15, 64, "R8");
        apply(1'b1, 3, 3, 15, 1, "R8");
        apply(1'b1, 3, 3, 15, 0, "R8");

        // R9: table 1, trigger 16, nonzero code ignored -> 24 / 8
        apply(1'b1, 1, 1, 5, 23, "R9");
        apply(1'b1, 1, 1, 9, 24, "R9");
        apply(1'b1, 1, 1, 9, 9, "R9");
        apply(1'b1, 1, 1, 2, 8, "R9");

        // R10: effect appears only after the edge
        @(negedge clk);
        rx_count = 7'd64;
        #1;
        check("R10", 1'b0);
        exp_rts = 1'b1;
        @(posedge clk);
        #1;
        check("R10", 1'b1);
        apply(1'b1, 1, 1, 2, 0, "R10");

        // Random walk against the model
        begin
            int t = 0;
            int i = 0;
            int h = 0;
            int c = 0;
            logic e = 1'b1;
            string tag;
            for (int k = 0; k < 4000; k++) begin
                if (k % 64 == 0) begin
                    t = int'($urandom_range(3, 0));
                    i = int'($urandom_range(3, 0));
                    h = ($urandom_range(3, 0) == 0) ? 0 : int'($urandom_range(15, 1));
                    e = ($urandom_range(7, 0) != 0);
                end
                c = c + int'($urandom_range(12, 0)) - 6;
                if (c < 0) c = 0;
                if (c > 64) c = 64;
                if (!e) tag = "R2";
                else if (t == 3 && h != 0) tag = "R8";
                else if (t == 3) tag = "R7";
                else if (h != 0) tag = "R9";
                else tag = "R5";
                apply(e, t, i, h, c, tag);
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule